// File: doc/BRIEF.md
# Character Cell Row Renderer

This block turns one row of one character cell into the five pixels a dot-matrix character display shows. A requester hands it a character code, a row index from 0 to 7 and a flag that marks the cell holding the cursor. One cycle after the request is accepted, the block returns the five-pixel row. Codes below 0x10 take their pattern from a 64-byte user-programmable glyph RAM that holds eight custom characters. All other codes take their pattern from a computed stand-in for the font ROM.

Three plain control levels shape the result:
- `disp_on` turns the whole display dark when low.
- `cursor_on` draws an underline on the last row of the cursor cell.
- `blink_on` makes the cursor cell alternate with a solid block. A cycle divider sets the length of each half-period, which is 0.4 s by default.

The glyph RAM is loaded through a plain byte write port.

Both the request and the response are valid/ready streams:
- A request transfers on a clock edge where `req_valid` and `req_ready` are both high.
- `req_ready` is high whenever the output register is empty or is being drained in the same cycle.
- A response transfers when `rsp_valid` and `rsp_ready` are both high.
- While `rsp_valid` is high and `rsp_ready` is low, the response and its pixels hold steady, and no new request is taken.

Top module: `glyph_row_render`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at glyph RAM byte `wr_addr`. Byte address = slot*8 + row.
- R2: A code below 0x10 selects slot = code bits 2..0 and ignores code bit 3, so 0x03 and 0x0B show the same glyph. The RAM byte is slot*8 + row.
- R3: From a glyph byte, only bits 4..0 are shown. Byte bit 4 appears on `rsp_pixels[4]`, which is the leftmost pixel, and byte bits 7..5 have no effect.
- R4: A code of 0x10 or above yields the stub font row `code[4:0] XOR {2'b00,row}`.
- R5: With `cursor_on` high, a request marked as the cursor cell for row 7 returns the glyph row ORed with all ones. Other rows, and cells that are not the cursor, are unchanged.
- R6: The blink phase starts at 0 and toggles after every BLINK_CYCLES clock edges while `blink_on` is high. It returns to 0, with its count cleared, while `blink_on` is low. With `blink_on` high and the phase at 1, a cursor-cell request returns all ones.
- R7: Cursor underline and blink can be active at the same time. In blink phase 0 the underline still shows on row 7.
- R8: With `disp_on` low, every accepted request returns all zeros. RAM contents are kept and show again once `disp_on` returns high.
- R9: The response appears on the clock edge after the request is accepted. `req_ready` equals `!rsp_valid || rsp_ready`. A stalled response keeps `rsp_pixels` stable.
- R10: After reset, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Glyph RAM write strobe |
| wr_addr | input | 6 | Glyph RAM byte address |
| wr_data | input | 8 | Glyph RAM write byte |
| disp_on | input | 1 | Display enable |
| cursor_on | input | 1 | Cursor underline enable |
| blink_on | input | 1 | Cursor block blink enable |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted |
| req_code | input | 8 | Character code |
| req_row | input | 3 | Row index inside the cell |
| req_at_cursor | input | 1 | Cell is at the cursor position |
| rsp_valid | output | 1 | Pixel row valid |
| rsp_ready | input | 1 | Consumer takes the pixel row |
| rsp_pixels | output | 5 | Pixel row, bit 4 leftmost |

## Verification
The bench sets BLINK_CYCLES to 8 instead of the 0.4 s default count, so each blink half-period lasts eight edges. This lets a short burst of cursor-cell lookups span several phase flips, and lets the bench see the phase reset when blink turns off and on again. The code, slot and row widths keep their defaults, so all sixteen low codes alias over the full 64-byte RAM. A repeating stall pattern on `rsp_ready` exercises holding a response while a request waits.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
  localparam int unsigned PIX_W = 5;
  typedef logic [PIX_W-1:0] pix_row_t;

  // Stand-in font: row pattern computed from code and row index
  function automatic pix_row_t stub_font(input logic [4:0] code_lo, input logic [2:0] row);
    return code_lo ^ {2'b00, row};
  endfunction
endpackage

// File: rtl/glyph_ram.sv
module glyph_ram #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned OUT_W  = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [OUT_W-1:0]  rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // only the displayed low bits leave the array
  assign rdata = mem[raddr][OUT_W-1:0];
endmodule

// File: rtl/glyph_blink_timer.sv
module glyph_blink_timer #(
  parameter int unsigned BLINK_CYCLES = 40_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic phase
);
  localparam int unsigned CNT_W = (BLINK_CYCLES > 1) ? $clog2(BLINK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLINK_CYCLES - 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (!enable) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (cnt == LAST) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/glyph_row_render.sv
module glyph_row_render #(
  parameter int unsigned BLINK_CYCLES = 40_000_000,
  parameter int unsigned CODE_W       = 8,
  parameter int unsigned ROW_W        = 3,
  parameter int unsigned SLOT_W       = 3,
  parameter int unsigned BYTE_W       = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [SLOT_W+ROW_W-1:0]      wr_addr,
  input  logic [BYTE_W-1:0]            wr_data,
  input  logic                         disp_on,
  input  logic                         cursor_on,
  input  logic                         blink_on,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [CODE_W-1:0]            req_code,
  input  logic [ROW_W-1:0]             req_row,
  input  logic                         req_at_cursor,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic [glyph_pkg::PIX_W-1:0]  rsp_pixels
);
  import glyph_pkg::*;

  localparam int unsigned ADDR_W = SLOT_W + ROW_W;
  localparam logic [ROW_W-1:0] CURSOR_ROW = '1;
  localparam int unsigned CUSTOM_TOP = SLOT_W + 1; // code bits at or above this must be zero

  logic [ADDR_W-1:0] rd_addr;
  pix_row_t          ram_row, font_row, next_row;
  logic              is_custom, blink_phase;

  // slot from low code bits; the next bit up is the ignored alias bit
  assign rd_addr   = {req_code[SLOT_W-1:0], req_row};
  assign is_custom = (req_code[CODE_W-1:CUSTOM_TOP] == '0);
  assign font_row  = stub_font(req_code[4:0], req_row);

  glyph_ram #(.DATA_W(BYTE_W), .ADDR_W(ADDR_W), .OUT_W(PIX_W)) i_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(ram_row)
  );

  glyph_blink_timer #(.BLINK_CYCLES(BLINK_CYCLES)) i_timer (
    .clk(clk), .rst_n(rst_n), .enable(blink_on), .phase(blink_phase)
  );

  always_comb begin
    next_row = is_custom ? ram_row : font_row;
    if (cursor_on && req_at_cursor && (req_row == CURSOR_ROW)) next_row = next_row | '1;
    if (blink_on && req_at_cursor && blink_phase) next_row = '1;
    if (!disp_on) next_row = '0;
  end

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_pixels <= '0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) rsp_pixels <= next_row;
    end
  end
endmodule

// File: rtl/glyph_row_render_chk.sv
module glyph_row_render_chk #(
  parameter int unsigned ROW_W = 3,
  parameter int unsigned PIX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [ROW_W-1:0] req_row,
  input logic             req_at_cursor,
  input logic             disp_on,
  input logic             cursor_on,
  input logic             blink_on,
  input logic             blink_phase,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PIX_W-1:0] rsp_pixels
);
  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R9
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pixels)); // R9
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R9
  AST_DARK_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !disp_on |=> rsp_pixels == '0); // R8
  AST_UNDERLINE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && disp_on && cursor_on && req_at_cursor && (req_row == '1)
    |=> rsp_pixels == '1); // R5
  AST_BLINK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !blink_on |=> !blink_phase); // R6
  AST_BLINK_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && disp_on && blink_on && blink_phase && req_at_cursor
    |=> rsp_pixels == '1); // R6
endmodule

bind glyph_row_render glyph_row_render_chk #(.ROW_W(ROW_W), .PIX_W(glyph_pkg::PIX_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_row(req_row), .req_at_cursor(req_at_cursor), .disp_on(disp_on),
  .cursor_on(cursor_on), .blink_on(blink_on), .blink_phase(blink_phase),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pixels(rsp_pixels)
);

// File: tb/test_glyph_row_render.sv
module test_glyph_row_render;
  localparam int BLINK = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic disp_on = 1'b1, cursor_on = 1'b0, blink_on = 1'b0;
  logic req_valid = 1'b0, req_at_cursor = 1'b0;
  logic [7:0] req_code = '0;
  logic [2:0] req_row = '0;
  logic rsp_ready = 1'b1;
  logic req_ready, rsp_valid;
  logic [4:0] rsp_pixels;

  always #5 clk = ~clk;

  glyph_row_render #(.BLINK_CYCLES(BLINK)) i_glyph_row_render (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .disp_on(disp_on), .cursor_on(cursor_on), .blink_on(blink_on),
    .req_valid(req_valid), .req_ready(req_ready), .req_code(req_code),
    .req_row(req_row), .req_at_cursor(req_at_cursor), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_pixels(rsp_pixels)
  );

  int checks = 0, fails = 0;
  logic [7:0] shadow [64];
  logic [4:0] exp_q[$];
  string tag_q[$];
  int bk = 0;
  bit stall_mode = 1'b0;
  int stall_cnt = 0;
  bit done = 1'b0;

  // edges seen with blink enabled (phase model from R6)
  always @(posedge clk) bk <= blink_on ? bk + 1 : 0;

  initial forever begin
    @(posedge clk); #1;
    stall_cnt++;
    rsp_ready = stall_mode ? (stall_cnt % 3 == 0) : 1'b1;
  end

  function automatic logic [4:0] predict(input logic [7:0] code, input logic [2:0] row, input logic atc);
    logic [4:0] p;
    if (code < 8'h10) p = shadow[{code[2:0], row}][4:0];   // R2 R3
    else p = code[4:0] ^ {2'b00, row};                      // R4
    if (cursor_on && atc && row == 3'd7) p = 5'h1F;          // R5
    if (blink_on && atc && ((bk / BLINK) % 2 == 1)) p = 5'h1F; // R6
    if (!disp_on) p = 5'h00;                                 // R8
    return p;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_byte(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    shadow[a] = d;
  endtask

  task automatic send(input logic [7:0] code, input logic [2:0] row, input logic atc, input string tag);
    @(negedge clk);
    req_code = code; req_row = row; req_at_cursor = atc; req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    exp_q.push_back(predict(code, row, atc));
    tag_q.push_back(tag);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compare each transferred response with the queue front
  initial forever begin
    @(negedge clk); #2;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R9_unexpected", rsp_pixels, 0);
      else begin
        logic [4:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_pixels === e, t, rsp_pixels, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rsp_valid === 1'b0, "R10_rsp_valid", rsp_valid, 0);
    check(req_ready === 1'b1, "R10_req_ready", req_ready, 1);
    rst_n = 1'b1;
    // R1: load every glyph byte, with bits 7..5 carrying noise
    for (int a = 0; a < 64; a++) write_byte(6'(a), 8'((a * 37 + 11) ^ 8'hA0));
    // R1 R2 R3: all sixteen low codes, every row
    for (int c = 0; c < 16; c++)
      for (int r = 0; r < 8; r++) send(8'(c), 3'(r), 1'b0, "R2_R3_custom");
    // R3: top bits set must not leak into pixels
    write_byte(6'd13, 8'hE0);
    send(8'h01, 3'd5, 1'b0, "R3_high_bits");
    write_byte(6'd13, 8'h10);
    send(8'h09, 3'd5, 1'b0, "R3_leftmost");
    // R4: font stub
    send(8'h10, 3'd0, 1'b0, "R4_font");
    send(8'h41, 3'd3, 1'b0, "R4_font");
    send(8'hFF, 3'd7, 1'b0, "R4_font");
    send(8'h2A, 3'd6, 1'b1, "R4_font_cursor_off");
    // R5: underline
    cursor_on = 1'b1;
    send(8'h02, 3'd7, 1'b1, "R5_underline");
    send(8'h52, 3'd7, 1'b1, "R5_underline_font");
    send(8'h02, 3'd3, 1'b1, "R5_other_row");
    send(8'h02, 3'd7, 1'b0, "R5_not_cursor");
    cursor_on = 1'b0;
    // R6: blink spans several phases
    @(negedge clk); blink_on = 1'b1;
    for (int i = 0; i < 40; i++) send(8'(i % 16), 3'(i % 7), 1'b1, "R6_blink");
    send(8'h05, 3'd2, 1'b0, "R6_not_cursor");
    @(negedge clk); blink_on = 1'b0;
    send(8'h05, 3'd2, 1'b1, "R6_blink_off");
    @(negedge clk); blink_on = 1'b1;
    send(8'h06, 3'd1, 1'b1, "R6_restart");
    // R7: cursor and blink together
    cursor_on = 1'b1;
    for (int i = 0; i < 24; i++) send(8'h44, 3'(i % 8), 1'b1, "R7_both");
    cursor_on = 1'b0;
    @(negedge clk); blink_on = 1'b0;
    // R8: dark display, RAM kept
    disp_on = 1'b0;
    send(8'h03, 3'd4, 1'b0, "R8_dark");
    send(8'h77, 3'd1, 1'b1, "R8_dark");
    write_byte(6'd20, 8'h15);
    disp_on = 1'b1;
    send(8'h02, 3'd4, 1'b0, "R8_restored");
    send(8'h04, 3'd0, 1'b0, "R8_restored");
    drain();
    // R9: back-pressure on the response
    stall_mode = 1'b1;
    for (int i = 0; i < 20; i++) send(8'(i * 13), 3'(i), 1'b0, "R9_stall");
    drain();
    stall_mode = 1'b0;
    repeat (4) @(negedge clk);
    check(rsp_valid === 1'b0, "R9_idle", rsp_valid, 0);
    finish_run();
  end
endmodule